// File: doc/BRIEF.md
# Serial Bitonic Sorter with Two-Bank Working Memory

The block sorts a run of words held in its own on-chip memory using a single compare-and-swap unit. A host loads words through a write port, pulses start with the base-2 logarithm of the run length and a direction flag, waits for the one-cycle done pulse, then reads the sorted words back through a read port. Run length is any power of two from 2 to 2^MAX_LOG (1024 by default) and is chosen per run.

A controller steps through every stage and sub-step of the bitonic network one pair at a time. For each pair a small generator derives both element indices by bit-permuting a pair counter: the counter is split at the sub-step bit and a zero is inserted there, the partner index has that bit set. Elements live in two banks picked by the parity of the index. The two elements of any pair differ in exactly one bit, so they always fall in opposite banks, and each bank needs only one read port and one write port. Each pair takes two cycles: read both banks, then compare and write both back.

Top module: `bitonic_sorter`

## Requirements
- R1: After reset busy_o and done_o are low.
- R2: While busy_o is low, a host write with wr_en_i stores wr_data_i at wr_addr_i, and rd_data_o returns the word at rd_addr_i one clock after rd_addr_i is presented.
- R3: After a run with log_len_i = k (1..MAX_LOG) and desc_i = 0, addresses 0..2^k-1 hold the loaded words in non-decreasing order, repeated values included, as a permutation of what was loaded.
- R4: With desc_i = 1 at start, addresses 0..2^k-1 hold the loaded words in non-increasing order.
- R5: Words at addresses 2^k and above are not changed by a run.
- R6: A start accepted while idle raises busy_o in the next cycle; busy_o stays high for exactly 2^k*k*(k+1)/2 cycles, and done_o is high for exactly one cycle, the first cycle after busy_o falls.
- R7: While busy_o is high, host writes and start_i are ignored: the run keeps its length, timing and result, and the written addresses keep their values.
- R8: A start with log_len_i = 0 leaves busy_o low, pulses done_o in the next cycle and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | MAX_LOG | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| rd_addr_i | input | MAX_LOG | Host read address |
| rd_data_o | output | DATA_W | Host read data, one cycle after the address |
| start_i | input | 1 | Start a run (sampled while idle) |
| log_len_i | input | LEN_W | log2 of run length, 0..MAX_LOG |
| desc_i | input | 1 | 1 sorts non-increasing, 0 non-decreasing |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last write-back |

## Verification
The collision that matters is a host write landing in the same cycle as the sorter's own write-back to the same bank, since both share that bank's single write port. The bench drives host writes to low and high addresses and a second start pulse on every cycle of a window in the middle of a 64-word run, so that some of them coincide with write-back cycles. It then judges that the run kept its exact cycle count, that the sorted region matches a bench-side sort of the data loaded before start, and that the written high address still holds its old value.

// File: rtl/sort_pkg.sv
package sort_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} sort_st_e;
endpackage

// File: rtl/srt_bank.sv
module srt_bank #(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ROW_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/srt_addr_gen.sv
module srt_addr_gen #(
  parameter int MAX_LOG = 10,
  parameter int LEN_W   = 4
) (
  input  logic [LEN_W-1:0]   stage_i,
  input  logic [LEN_W-1:0]   step_i,
  input  logic [MAX_LOG-2:0] pair_i,
  output logic [MAX_LOG-1:0] idx_a_o,
  output logic [MAX_LOG-1:0] idx_b_o,
  output logic               up_o
);
  localparam int IDX_W = MAX_LOG;
  logic [IDX_W-1:0] p_ext, hi, lo, bit_t;
  logic [IDX_W:0]   a_ext;

  // insert a zero at bit 'step' of the pair counter
  always_comb begin
    p_ext   = {1'b0, pair_i};
    bit_t   = IDX_W'(1) << step_i;
    hi      = (p_ext >> step_i) << (step_i + 1'b1);
    lo      = p_ext & (bit_t - 1'b1);
    idx_a_o = hi | lo;
    idx_b_o = idx_a_o | bit_t;
    a_ext   = {1'b0, idx_a_o};
    up_o    = ~a_ext[stage_i + 1'b1];
  end
endmodule

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import sort_pkg::*;
#(
  parameter int MAX_LOG = 10,
  parameter int LEN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   log_len_i,
  output logic [LEN_W-1:0]   stage_o,
  output logic [LEN_W-1:0]   step_o,
  output logic [MAX_LOG-2:0] pair_o,
  output logic               wr_phase_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int PAIR_W = MAX_LOG - 1;

  sort_st_e          st_q;
  logic [LEN_W-1:0]  k_q, s_q, t_q;
  logic [PAIR_W-1:0] p_q, last_p;
  logic [PAIR_W:0]   half;
  logic              done_q;

  always_comb begin
    half   = (PAIR_W + 1)'(1) << (k_q - 1'b1);
    last_p = PAIR_W'(half - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      s_q    <= '0;
      t_q    <= '0;
      p_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          if (log_len_i == '0) done_q <= 1'b1;
          else begin
            k_q  <= log_len_i;
            s_q  <= '0;
            t_q  <= '0;
            p_q  <= '0;
            st_q <= ST_RD;
          end
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          st_q <= ST_RD;
          if (p_q == last_p) begin
            p_q <= '0;
            if (t_q == '0) begin
              if (s_q == k_q - 1'b1) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                s_q <= s_q + 1'b1;
                t_q <= s_q + 1'b1;
              end
            end else t_q <= t_q - 1'b1;
          end else p_q <= p_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stage_o    = s_q;
  assign step_o     = t_q;
  assign pair_o     = p_q;
  assign wr_phase_o = (st_q == ST_WR);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (t_q <= s_q) && (s_q < k_q)); // R6
endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter #(
  parameter int DATA_W  = 16,
  parameter int MAX_LOG = 10,
  parameter int LEN_W   = $clog2(MAX_LOG + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [MAX_LOG-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [MAX_LOG-1:0] rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   log_len_i,
  input  logic               desc_i,
  output logic               busy_o,
  output logic               done_o
);
  localparam int IDX_W = MAX_LOG;
  localparam int ROW_W = IDX_W - 1;

  logic [LEN_W-1:0]  stage, step;
  logic [IDX_W-2:0]  pair;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic              up, wr_phase, desc_q, rsel_q, par_a, asc, swap, sort_we;
  logic [DATA_W-1:0] val_a, val_b, new_a, new_b;
  logic [DATA_W-1:0] rdata [2];

  srt_ctrl #(.MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .log_len_i,
    .stage_o(stage), .step_o(step), .pair_o(pair),
    .wr_phase_o(wr_phase), .busy_o, .done_o
  );

  srt_addr_gen #(.MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) u_agen (
    .stage_i(stage), .step_i(step), .pair_i(pair),
    .idx_a_o(idx_a), .idx_b_o(idx_b), .up_o(up)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= 1'b0;
      rsel_q <= 1'b0;
    end else begin
      if (start_i && !busy_o) desc_q <= desc_i;
      rsel_q <= ^rd_addr_i;
    end
  end

  // compare-and-swap; equal words are never swapped
  always_comb begin
    par_a   = ^idx_a;
    val_a   = par_a ? rdata[1] : rdata[0];
    val_b   = par_a ? rdata[0] : rdata[1];
    asc     = up ^ desc_q;
    swap    = asc ? (val_a > val_b) : (val_a < val_b);
    new_a   = swap ? val_b : val_a;
    new_b   = swap ? val_a : val_b;
    sort_we = busy_o && wr_phase;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BK = 1'(b);
    logic [ROW_W-1:0]  s_row, raddr, waddr;
    logic [DATA_W-1:0] wdata;
    logic              we, host_we;

    always_comb begin
      s_row   = (par_a == BK) ? idx_a[IDX_W-1:1] : idx_b[IDX_W-1:1];
      host_we = !busy_o && wr_en_i && ((^wr_addr_i) == BK);
      we      = sort_we || host_we;
      waddr   = sort_we ? s_row : wr_addr_i[IDX_W-1:1];
      wdata   = sort_we ? ((par_a == BK) ? new_a : new_b) : wr_data_i;
      raddr   = busy_o ? s_row : rd_addr_i[IDX_W-1:1];
    end

    srt_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_i(raddr), .rdata_o(rdata[b])
    );
  end

  assign rd_data_o = rdata[rsel_q];

  AST_PAIR_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((^idx_a) != (^idx_b))); // R3
  AST_PAIR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sort_we |-> (asc ? (g_bank[0].wdata <= g_bank[1].wdata) == !par_a || g_bank[0].wdata == g_bank[1].wdata
                     : (g_bank[0].wdata >= g_bank[1].wdata) == !par_a || g_bank[0].wdata == g_bank[1].wdata)); // R4
  AST_HOST_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_phase) |-> !(g_bank[0].we || g_bank[1].we)); // R7
endmodule

// File: tb/tb_bitonic_sorter.sv
module tb_bitonic_sorter;
  localparam int DATA_W = 16;
  localparam int MAX_LOG = 10;
  localparam int LEN_W = 4;
  localparam int NMAX = 1 << MAX_LOG;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, start_i = 1'b0, desc_i = 1'b0;
  logic [MAX_LOG-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0, rd_data_o;
  logic [LEN_W-1:0] log_len_i = '0;
  logic busy_o, done_o;

  int total = 0, bad = 0;
  logic [DATA_W-1:0] model [NMAX];

  always #5 clk = ~clk;

  bitonic_sorter #(.DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .rd_data_o, .start_i, .log_len_i, .desc_i, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = MAX_LOG'(a); wr_data_i = DATA_W'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
    model[a] = DATA_W'(d);
  endtask

  task automatic hread(input int a, output int d);
    @(negedge clk);
    rd_addr_i = MAX_LOG'(a);
    @(negedge clk);
    d = int'(rd_data_o);
  endtask

  task automatic sort_model(input int n, input bit dsc);
    for (int i = 1; i < n; i++) begin
      logic [DATA_W-1:0] v = model[i];
      int j = i - 1;
      while (j >= 0 && (dsc ? model[j] < v : model[j] > v)) begin
        model[j+1] = model[j];
        j--;
      end
      model[j+1] = v;
    end
  endtask

  // run a sort; inject=1 fires host writes and start pulses mid-run (R7)
  task automatic run(input int k, input bit dsc, input bit inject, input string req);
    int n = 1 << k;
    int exp_cyc = n * k * (k + 1) / 2;
    int cyc = 0;
    int d;
    logic [DATA_W-1:0] hi_old = model[NMAX-1];
    @(negedge clk);
    start_i = 1'b1; log_len_i = LEN_W'(k); desc_i = dsc;
    @(negedge clk);
    start_i = 1'b0;
    if (k == 0) begin
      chk(!busy_o, "R8 busy", busy_o, 0);
      chk(done_o, "R8 done", done_o, 1);
      @(negedge clk);
      chk(!done_o, "R8 done width", done_o, 0);
    end else begin
      chk(busy_o, "R6 busy rise", busy_o, 1);
      while (busy_o && cyc < 100000) begin
        if (done_o) chk(0, "R6 done early", 1, 0);
        if (inject && cyc >= 20 && cyc < 40) begin
          wr_en_i = 1'b1; wr_addr_i = MAX_LOG'((cyc & 1) ? NMAX - 1 : 3);
          wr_data_i = 16'hdead; start_i = 1'b1; log_len_i = 4'd2; desc_i = ~dsc;
        end else begin
          wr_en_i = 1'b0; start_i = 1'b0;
        end
        cyc++;
        @(negedge clk);
      end
      wr_en_i = 1'b0; start_i = 1'b0;
      if (cyc >= 100000) chk(0, "watchdog", cyc, exp_cyc);
      chk(cyc == exp_cyc, {req, " R6 busy cycles"}, cyc, exp_cyc);
      chk(done_o, "R6 done pulse", done_o, 1);
      @(negedge clk);
      chk(!done_o, "R6 done width", done_o, 0);
      sort_model(n, dsc);
    end
    for (int i = 0; i < n && k > 0; i++) begin
      hread(i, d);
      chk(d == int'(model[i]), dsc ? "R4 order" : "R3 order", d, model[i]);
    end
    for (int i = n; i < n + 4 && i < NMAX; i++) begin
      hread(i, d);
      chk(d == int'(model[i]), "R5 untouched", d, model[i]);
    end
    if (inject) begin
      hread(NMAX - 1, d);
      chk(d == int'(hi_old), "R7 write ignored", d, hi_old);
    end
  endtask

  initial begin
    int d;
    void'($urandom(32'h5eed));
    #23 rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_o, "R1 done", done_o, 0);
    for (int i = 0; i < NMAX; i++) hwrite(i, $urandom & 16'hffff);
    for (int i = 0; i < 8; i++) begin
      hread(i * 131, d);
      chk(d == int'(model[i * 131]), "R2 readback", d, model[i * 131]);
    end
    run(1, 1'b0, 1'b0, "R3 k1");
    run(3, 1'b1, 1'b0, "R4 k3");
    for (int i = 0; i < 32; i++) hwrite(i, 7);
    run(5, 1'b0, 1'b0, "R3 equal");
    for (int i = 0; i < 16; i++) hwrite(i, 1000 - i * 3);
    run(4, 1'b0, 1'b0, "R3 reversed");
    for (int i = 0; i < 4; i++) hwrite(i, $urandom % 4);
    run(2, 1'b1, 1'b0, "R4 dups");
    run(0, 1'b0, 1'b0, "R8");
    hread(0, d);
    chk(d == int'(model[0]), "R8 unchanged", d, model[0]);
    for (int i = 0; i < 64; i++) hwrite(i, $urandom % 50);
    run(6, 1'b0, 1'b1, "R7 inject");
    for (int i = 0; i < NMAX; i++) hwrite(i, $urandom & 16'hffff);
    run(MAX_LOG, 1'b0, 1'b0, "R3 full");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1900000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule